// File: doc/BRIEF.md
# Split-View Doorbell Mailbox Channel

This block is one doorbell channel between two processors. The sender and the receiver each have their own 32-bit register frame on a simple word-wide bus. Each bus has a select, a write strobe, a 12-bit byte offset, write data, a secure-access flag and combinational read data. Both frames share one 32-bit status word. The sender raises doorbell bits through a write-one-to-set register. The receiver acknowledges them through a write-one-to-clear register. The receiver gets a level interrupt while any usable doorbell bit is pending.

Before it rings, the sender can wake the receiver. It writes a wake request in its own frame, which drives the `wake_req` output. It then polls a ready register that follows the receiver's `wake_ack` input. The mailbox only raises and withdraws the request and never puts the receiver to sleep. Status bit 31 is reserved as a violation flag. The hardware sets it whenever a non-secure access reaches either frame, and such an access changes nothing else.

Top module: `mbx_doorbell`

## Requirements
- R1: After synchronous reset the status word reads 0 in both frames, `wake_req` is 0, the ready register reads 0 and `rx_irq` is 0.
- R2: A secure sender write to offset 0x00C ORs write-data bits 30:0 into the status word on the next clock edge. Write-data bit 31 is ignored.
- R3: A secure receiver write to offset 0x008 clears every status bit, bit 31 included, whose write-data bit is 1 on the next clock edge. All other bits are kept.
- R4: Offset 0x000 reads the status word in both frames. Read data is combinational with the selected offset, in the same cycle as the select.
- R5: When a set and a clear land on the same clock edge, the new status is (old AND NOT clear) OR set, so the set wins on bits that both touch.
- R6: A secure sender write to offset 0xF88 loads write-data bit 0 into the wake request. `wake_req` then shows it after the edge, and offset 0xF88 reads it back in bit 0.
- R7: Sender offset 0xF8C bit 0 reads `wake_ack` as sampled at the previous clock edge, which is one register stage of delay.
- R8: Any access with the secure flag low, read or write, on either frame, sets status bit 31 on the next edge and has no other effect. Its read data is 0.
- R9: `rx_irq` is 1 exactly when any status bit 30:0 is 1. Bit 31 alone does not raise it.
- R10: Secure reads of any offset not listed above return 0. Secure writes to read-only or unlisted offsets have no effect: the receiver writing at 0x00C, the sender writing at 0x000, 0x008 or 0xF8C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_sel | input | 1 | Sender frame access select |
| tx_wr | input | 1 | Sender access is a write |
| tx_addr | input | 12 | Sender byte offset |
| tx_wdata | input | 32 | Sender write data |
| tx_secure | input | 1 | Sender access is secure |
| tx_rdata | output | 32 | Sender read data |
| rx_sel | input | 1 | Receiver frame access select |
| rx_wr | input | 1 | Receiver access is a write |
| rx_addr | input | 12 | Receiver byte offset |
| rx_wdata | input | 32 | Receiver write data |
| rx_secure | input | 1 | Receiver access is secure |
| rx_rdata | output | 32 | Receiver read data |
| wake_ack | input | 1 | Receiver reports it is awake |
| wake_req | output | 1 | Wake request to the receiver |
| rx_irq | output | 1 | Level doorbell interrupt to the receiver |

## Verification
Every write takes effect at the first clock edge that samples it. The bench drives each access on a falling edge and checks the effect at the next falling edge, which is one register stage later, through combinational reads and `rx_irq`. Read data and the zero result of a non-secure read are checked 1 ns after the select is driven, before any edge. The ready register is checked once before and once after the single edge that follows a `wake_ack` change. This confirms the one-stage delay of R7.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned ADDR_W   = 12;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned VIOL_BIT = DATA_W - 1;

    localparam logic [ADDR_W-1:0] OFF_STATUS   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_CLEAR    = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_SET      = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_WAKE_REQ = 12'hF88;
    localparam logic [ADDR_W-1:0] OFF_WAKE_RDY = 12'hF8C;

    localparam logic [DATA_W-1:0] SLOT_MASK = {1'b0, {(DATA_W-1){1'b1}}};

    typedef struct packed {
        logic              set_we;
        logic [DATA_W-1:0] set_mask;
        logic              req_we;
        logic              req_val;
        logic              viol;
    } tx_cmd_t;

    typedef struct packed {
        logic              clr_we;
        logic [DATA_W-1:0] clr_mask;
        logic              viol;
    } rx_cmd_t;

    typedef enum logic [1:0] {
        SRC_ZERO,
        SRC_STATUS,
        SRC_REQ,
        SRC_RDY
    } rd_src_e;

    function automatic rd_src_e tx_read_src(logic sel, logic secure,
                                            logic [ADDR_W-1:0] addr);
        if (!sel || !secure)          return SRC_ZERO;
        else if (addr == OFF_STATUS)  return SRC_STATUS;
        else if (addr == OFF_WAKE_REQ) return SRC_REQ;
        else if (addr == OFF_WAKE_RDY) return SRC_RDY;
        else                          return SRC_ZERO;
    endfunction

    function automatic logic [DATA_W-1:0] flag_word(logic b);
        return {{(DATA_W-1){1'b0}}, b};
    endfunction

endpackage

// File: rtl/mbx_tx_decode.sv
module mbx_tx_decode
    import mbx_pkg::*;
(
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              secure,
    input  logic [DATA_W-1:0] status,
    input  logic              req,
    input  logic              rdy,
    output tx_cmd_t           cmd,
    output logic [DATA_W-1:0] rdata
);
    logic    sec_wr;
    rd_src_e src;

    assign sec_wr = sel && wr && secure;

    always_comb begin
        cmd          = '0;
        cmd.viol     = sel && !secure;
        cmd.set_we   = sec_wr && (addr == OFF_SET);
        cmd.set_mask = wdata & SLOT_MASK;
        cmd.req_we   = sec_wr && (addr == OFF_WAKE_REQ);
        cmd.req_val  = wdata[0];
    end

    assign src = tx_read_src(sel, secure, addr);

    always_comb begin
        unique case (src)
            SRC_STATUS: rdata = status;
            SRC_REQ:    rdata = flag_word(req);
            SRC_RDY:    rdata = flag_word(rdy);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbx_rx_decode.sv
module mbx_rx_decode
    import mbx_pkg::*;
(
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              secure,
    input  logic [DATA_W-1:0] status,
    output rx_cmd_t           cmd,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        cmd          = '0;
        cmd.viol     = sel && !secure;
        cmd.clr_we   = sel && wr && secure && (addr == OFF_CLEAR);
        cmd.clr_mask = wdata;
    end

    assign rdata = (sel && secure && (addr == OFF_STATUS)) ? status : '0;
endmodule

// File: rtl/mbx_status_core.sv
module mbx_status_core
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic [DATA_W-1:0] set_mask,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] clr_mask,
    input  logic              viol,
    output logic [DATA_W-1:0] status
);
    logic [DATA_W-1:0] clr_eff, set_eff, viol_eff, status_nx;

    assign clr_eff   = clr_we ? clr_mask : '0;
    assign set_eff   = set_we ? set_mask : '0;
    assign viol_eff  = viol ? (DATA_W'(1) << VIOL_BIT) : '0;
    assign status_nx = (status & ~clr_eff) | set_eff | viol_eff;

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= status_nx;
    end

    // R1
    status_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> status == '0);

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((status & $past(set_mask)) == $past(set_mask)));

    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we && !viol) |=> ((status & $past(clr_mask)) == '0));

    // R8
    viol_flag_chk: assert property (@(posedge clk) disable iff (rst)
        viol |=> status[VIOL_BIT]);
endmodule

// File: rtl/mbx_wake_ctl.sv
module mbx_wake_ctl (
    input  logic clk,
    input  logic rst,
    input  logic req_we,
    input  logic req_val,
    input  logic wake_ack,
    output logic wake_req,
    output logic ready
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wake_req <= 1'b0;
            ready    <= 1'b0;
        end else begin
            if (req_we) wake_req <= req_val;
            ready <= wake_ack;
        end
    end

    // R7
    ready_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ready == $past(wake_ack));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(req_we)) |-> wake_req == $past(wake_req));
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tx_sel,
    input  logic        tx_wr,
    input  logic [11:0] tx_addr,
    input  logic [31:0] tx_wdata,
    input  logic        tx_secure,
    output logic [31:0] tx_rdata,
    input  logic        rx_sel,
    input  logic        rx_wr,
    input  logic [11:0] rx_addr,
    input  logic [31:0] rx_wdata,
    input  logic        rx_secure,
    output logic [31:0] rx_rdata,
    input  logic        wake_ack,
    output logic        wake_req,
    output logic        rx_irq
);
    tx_cmd_t           tx_cmd;
    rx_cmd_t           rx_cmd;
    logic [DATA_W-1:0] status;
    logic              ready;

    mbx_tx_decode tx_dec_i (
        .sel(tx_sel), .wr(tx_wr), .addr(tx_addr), .wdata(tx_wdata),
        .secure(tx_secure), .status(status), .req(wake_req), .rdy(ready),
        .cmd(tx_cmd), .rdata(tx_rdata)
    );

    mbx_rx_decode rx_dec_i (
        .sel(rx_sel), .wr(rx_wr), .addr(rx_addr), .wdata(rx_wdata),
        .secure(rx_secure), .status(status), .cmd(rx_cmd), .rdata(rx_rdata)
    );

    mbx_status_core core_i (
        .clk(clk), .rst(rst),
        .set_we(tx_cmd.set_we), .set_mask(tx_cmd.set_mask),
        .clr_we(rx_cmd.clr_we), .clr_mask(rx_cmd.clr_mask),
        .viol(tx_cmd.viol || rx_cmd.viol),
        .status(status)
    );

    mbx_wake_ctl wake_i (
        .clk(clk), .rst(rst),
        .req_we(tx_cmd.req_we), .req_val(tx_cmd.req_val),
        .wake_ack(wake_ack), .wake_req(wake_req), .ready(ready)
    );

    assign rx_irq = |status[VIOL_BIT-1:0];

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_irq) |-> $past(tx_cmd.set_we));
endmodule

// File: tb/mbx_doorbell_tb_top.sv
module mbx_doorbell_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] MASK = 32'h7FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_sel = 0, tx_wr = 0, tx_secure = 1;
    logic [11:0] tx_addr = 0;
    logic [31:0] tx_wdata = 0;
    logic [31:0] tx_rdata;
    logic        rx_sel = 0, rx_wr = 0, rx_secure = 1;
    logic [11:0] rx_addr = 0;
    logic [31:0] rx_wdata = 0;
    logic [31:0] rx_rdata;
    logic        wake_ack = 0;
    logic        wake_req, rx_irq;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_st = 0;
    logic [31:0] lcg = 32'h1234_5678;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_doorbell dut_i (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tx_acc(logic wr, logic [11:0] a, logic [31:0] d, logic sec);
        @(negedge clk);
        tx_sel = 1; tx_wr = wr; tx_addr = a; tx_wdata = d; tx_secure = sec;
        #1 rd = tx_rdata;
        @(negedge clk);
        tx_sel = 0; tx_wr = 0; tx_secure = 1;
    endtask

    task automatic rx_acc(logic wr, logic [11:0] a, logic [31:0] d, logic sec);
        @(negedge clk);
        rx_sel = 1; rx_wr = wr; rx_addr = a; rx_wdata = d; rx_secure = sec;
        #1 rd = rx_rdata;
        @(negedge clk);
        rx_sel = 0; rx_wr = 0; rx_secure = 1;
    endtask

    task automatic check_status(string req);
        tx_acc(0, 12'h000, 0, 1);
        chk(req, rd, exp_st);
        rx_acc(0, 12'h000, 0, 1);
        chk(req, rd, exp_st);
        chk(req, {31'b0, rx_irq}, {31'b0, |exp_st[30:0]});
    endtask

    initial begin
        #(CLK_PERIOD*60000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", {31'b0, wake_req}, 0);
        chk("R1", {31'b0, rx_irq}, 0);
        tx_acc(0, 12'hF8C, 0, 1); chk("R1", rd, 0);
        check_status("R1");

        // R2 R9 R3: every single bit in turn, bit 31 of set data ignored
        for (int b = 0; b < 32; b++) begin
            tx_acc(1, 12'h00C, 32'h1 << b, 1);
            exp_st |= (32'h1 << b) & MASK;
            check_status("R2");
            chk("R9", {31'b0, rx_irq}, {31'b0, b != 31});
            rx_acc(1, 12'h008, 32'h1 << b, 1);
            exp_st &= ~(32'h1 << b);
            check_status("R3");
        end

        // R2 R3 R4: arithmetic patterns
        for (int i = 0; i < 40; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            tx_acc(1, 12'h00C, lcg, 1);
            exp_st |= lcg & MASK;
            check_status("R4");
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            rx_acc(1, 12'h008, lcg, 1);
            exp_st &= ~lcg;
            check_status("R3");
        end

        // R5 simultaneous set and clear
        for (int i = 0; i < 8; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            @(negedge clk);
            tx_sel = 1; tx_wr = 1; tx_addr = 12'h00C; tx_wdata = lcg ^ 32'h00FF_00FF;
            rx_sel = 1; rx_wr = 1; rx_addr = 12'h008; rx_wdata = lcg;
            @(negedge clk);
            tx_sel = 0; tx_wr = 0; rx_sel = 0; rx_wr = 0;
            exp_st = (exp_st & ~lcg) | ((lcg ^ 32'h00FF_00FF) & MASK);
            check_status("R5");
        end
        rx_acc(1, 12'h008, 32'hFFFF_FFFF, 1); exp_st = 0;

        // R8 non-secure accesses: only bit 31
        tx_acc(1, 12'h00C, 32'h0000_00F0, 0);
        exp_st[31] = 1;
        chk("R8", rd, 0);
        check_status("R8");
        chk("R8", {31'b0, rx_irq}, 0);
        tx_acc(1, 12'hF88, 32'h1, 0);
        chk("R8", {31'b0, wake_req}, 0);
        rx_acc(1, 12'h008, 32'hFFFF_FFFF, 0);
        check_status("R8");
        tx_acc(0, 12'h000, 0, 0); chk("R8", rd, 0);
        rx_acc(0, 12'h000, 0, 0); chk("R8", rd, 0);
        rx_acc(1, 12'h008, 32'h8000_0000, 1); exp_st = 0;
        check_status("R3");

        // R6 wake request
        tx_acc(1, 12'hF88, 32'h1, 1);
        chk("R6", {31'b0, wake_req}, 1);
        tx_acc(0, 12'hF88, 0, 1); chk("R6", rd, 1);
        // R7 ready delay
        @(negedge clk); wake_ack = 1;
        tx_sel = 1; tx_wr = 0; tx_addr = 12'hF8C;
        #1 chk("R7", tx_rdata, 0);
        @(negedge clk); #1 chk("R7", tx_rdata, 1);
        tx_sel = 0;
        tx_acc(1, 12'hF88, 32'h0, 1);
        chk("R6", {31'b0, wake_req}, 0);
        @(negedge clk); wake_ack = 0;
        @(negedge clk); tx_acc(0, 12'hF8C, 0, 1); chk("R7", rd, 0);

        // R10 unmapped and read-only
        tx_acc(1, 12'h00C, 32'h0000_0A05, 1); exp_st = 32'h0000_0A05;
        rx_acc(1, 12'h00C, 32'hFFFF_FFFF, 1);
        tx_acc(1, 12'h000, 32'h0, 1);
        tx_acc(1, 12'h008, 32'hFFFF_FFFF, 1);
        tx_acc(1, 12'hF8C, 32'h1, 1);
        check_status("R10");
        tx_acc(0, 12'hF8C, 0, 1); chk("R10", rd, 0);
        chk("R10", {31'b0, wake_req}, 0);
        rx_acc(1, 12'hF88, 32'h1, 1);
        chk("R10", {31'b0, wake_req}, 0);
        for (int a = 4; a < 4096; a += 4) begin
            if (a != 12'hF88 && a != 12'hF8C) begin
                tx_acc(0, 12'(a), 0, 1); chk("R10", rd, 0);
            end
            rx_acc(0, 12'(a), 0, 1); chk("R10", rd, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule